// File: doc/BRIEF.md
# SDLC Frame Receiver with Station Address Filter

This block receives a bit-synchronous data link stream. A single-cycle strobe `bit_en` qualifies each bit on `rx_bit`. The block finds the 01111110 boundary pattern and removes the zeros the sender inserted for transparency. It packs the remaining bits into bytes, first bit received as the least significant bit. At the closing boundary it checks the 16-bit frame check sequence. Delivered bytes leave one at a time on a one-cycle `out_valid` pulse. `out_sof` marks the first byte of a frame and `out_eof` marks its last data byte. `out_crc_err` is reported alongside `out_eof`. The two check bytes are never delivered.

When `addr_search` is high, the first byte of each frame is compared with `station_addr`. A frame with a different address is dropped in full. A matching frame is delivered with its address byte. When `addr_search` is low, every well-formed frame is delivered.

The controller has three states. HUNT waits for a boundary pattern. OPEN has seen a boundary and waits for the first byte. FRAME is collecting a frame. The transitions are:
- HUNT to OPEN on a boundary.
- OPEN to OPEN on a repeated boundary.
- OPEN to FRAME on an accepted first byte.
- OPEN to HUNT on a rejected first byte.
- FRAME to OPEN on the closing boundary, which also opens the next frame.
- OPEN or FRAME to HUNT on a run of seven ones.

Top module: `sdlc_rx`

## Requirements
- R1: After reset, all outputs are low, the receiver is in HUNT, and it delivers nothing until it has seen a boundary pattern.
- R2: A boundary is the bit sequence 0,1,1,1,1,1,1,0 in arrival order. Bits received while hunting produce no output.
- R3: Between boundaries, a 0 that follows five consecutive 1s is removed. Byte values that contain 0x7E or 0xFF are delivered unchanged.
- R4: Bytes are assembled with the first bit received as bit 0. Each delivered byte appears as a one-cycle `out_valid` pulse in the clock cycle after a `bit_en` strobe.
- R5: `out_sof` is high only with the first delivered byte of a frame. `out_eof` is high only with the last byte before the two check bytes, and it is released at the closing boundary. The check bytes are never output.
- R6: The check register is preset to all ones at each boundary. It uses the bit-reversed CCITT polynomial 0x8408 and processes each byte least significant bit first. The sender appends the one's complement of the register, low byte first. `out_crc_err` is low when the final remainder equals 0xF0B8, and high otherwise.
- R7: One boundary closes a frame and opens the next. The final 0 of one boundary may also serve as the first 0 of the following one.
- R8: With `addr_search` high, a frame whose first byte differs from `station_addr` produces no output. A matching frame is delivered starting with its address byte.
- R9: With `addr_search` low, every frame of three or more bytes is delivered, including its first byte.
- R10: A frame of fewer than three bytes between boundaries produces no output.
- R11: Seven consecutive 1s return the receiver to HUNT. A frame that has not yet released a byte then produces no output and no `out_eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe qualifying `rx_bit` |
| rx_bit | input | 1 | Received serial data bit |
| addr_search | input | 1 | High to filter frames by station address |
| station_addr | input | 8 | Address accepted in search mode |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a delivered byte |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last data byte of a frame |
| out_crc_err | output | 1 | Check sequence mismatch, valid with `out_eof` |

## Verification
The bench builds the block with its defaults: a 16-bit check register, polynomial 0x8408, preset all ones and expected remainder 0xF0B8. With these values the delivery delay is three bytes, so address-plus-check-only frames and two-byte fragments are exactly at the short-frame limit. A check sequence computed by the bench can then be compared against the receiver's verdict, both intact and with one bit flipped. The same settings expose the shared-zero boundary case and the abort case, where a frame ends while all of its bytes are still held back.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_OPEN,
        ST_FRAME
    } rx_state_e;

    // number of ones after which a zero is a stuffed bit
    localparam int STUFF_RUN = 5;
    // run of ones inside a boundary pattern
    localparam int FLAG_RUN  = 6;
endpackage

// File: rtl/sdlc_rx_deframe.sv
module sdlc_rx_deframe
    import sdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic d_valid,
    output logic d_bit,
    output logic flag_hit,
    output logic abort_hit
);
    localparam logic [2:0] RUN_MAX = 3'd7;
    localparam logic [2:0] STUFF_N = 3'(STUFF_RUN);
    localparam logic [2:0] FLAG_N  = 3'(FLAG_RUN);

    logic [2:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (rx_bit) begin
                ones_q <= (ones_q == RUN_MAX) ? RUN_MAX : ones_q + 3'd1;
            end else begin
                ones_q <= '0;
            end
        end
    end

    // a bit is payload only while the run of ones is short enough
    always_comb begin
        d_valid   = bit_en && (ones_q < STUFF_N);
        d_bit     = rx_bit;
        flag_hit  = bit_en && !rx_bit && (ones_q == FLAG_N);
        abort_hit = bit_en &&  rx_bit && (ones_q == FLAG_N);
    end
endmodule

// File: rtl/sdlc_rx_crc.sv
module sdlc_rx_crc #(
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_q
);
    function automatic logic [CRC_W-1:0] step_byte(
        input logic [CRC_W-1:0] c_in,
        input logic [7:0]       b
    );
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ CRC_POLY;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= CRC_INIT;
        else if (init)  crc_q <= CRC_INIT;
        else if (upd)   crc_q <= step_byte(crc_q, byte_in);
    end
endmodule

// File: rtl/sdlc_rx.sv
module sdlc_rx
    import sdlc_rx_pkg::*;
#(
    parameter int               CRC_W       = 16,
    parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
    parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       addr_search,
    input  logic [7:0] station_addr,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_crc_err
);
    localparam int               FCS_BYTES = CRC_W / 8;
    localparam int               DEPTH     = FCS_BYTES + 1;
    localparam int               FILL_W    = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FULL     = FILL_W'(DEPTH);
    // payload bits a closing boundary leaves behind: its zero and five ones
    localparam logic [2:0]       ALIGN     = 3'(STUFF_RUN + 1);

    rx_state_e state_q, state_d;

    logic             d_valid, d_bit, flag_hit, abort_hit;
    logic [6:0]       sh_q;
    logic [2:0]       bitcnt_q;
    logic [FILL_W-1:0] fill_q;
    logic             first_q;
    logic [7:0]       hold_q [DEPTH];
    logic [CRC_W-1:0] crc_q;
    logic [7:0]       byte_w;
    logic             data_ok, byte_done, reject, push;

    sdlc_rx_deframe u_deframe (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .d_valid  (d_valid),
        .d_bit    (d_bit),
        .flag_hit (flag_hit),
        .abort_hit(abort_hit)
    );

    sdlc_rx_crc #(
        .CRC_W   (CRC_W),
        .CRC_POLY(CRC_POLY),
        .CRC_INIT(CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (flag_hit),
        .upd    (push),
        .byte_in(byte_w),
        .crc_q  (crc_q)
    );

    always_comb begin
        byte_w    = {d_bit, sh_q};
        data_ok   = d_valid && (state_q != ST_HUNT);
        byte_done = data_ok && (bitcnt_q == 3'd7);
        reject    = byte_done && (state_q == ST_OPEN) && addr_search
                    && (byte_w != station_addr);
        push      = byte_done && !reject;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (flag_hit) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (abort_hit)      state_d = ST_HUNT;
                else if (flag_hit)  state_d = ST_OPEN;
                else if (reject)    state_d = ST_HUNT;
                else if (byte_done) state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (abort_hit)     state_d = ST_HUNT;
                else if (flag_hit) state_d = ST_OPEN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // delay line holding the latest DEPTH bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hold_q[i] <= '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH - 1; i++) hold_q[i] <= hold_q[i+1];
            hold_q[DEPTH-1] <= byte_w;
        end
    end

    // byte assembly and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q        <= '0;
            bitcnt_q    <= '0;
            fill_q      <= '0;
            first_q     <= 1'b1;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            out_crc_err <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_sof     <= 1'b0;
            out_eof     <= 1'b0;
            out_crc_err <= 1'b0;
            if (flag_hit) begin
                bitcnt_q <= '0;
                fill_q   <= '0;
                first_q  <= 1'b1;
                if (state_q == ST_FRAME && fill_q == FULL) begin
                    out_valid   <= 1'b1;
                    out_data    <= hold_q[0];
                    out_sof     <= first_q;
                    out_eof     <= 1'b1;
                    out_crc_err <= (crc_q != CRC_RESIDUE) || (bitcnt_q != ALIGN);
                end
            end else if (data_ok) begin
                sh_q     <= {d_bit, sh_q[6:1]};
                bitcnt_q <= bitcnt_q + 3'd1;
                if (push) begin
                    if (fill_q == FULL) begin
                        out_valid <= 1'b1;
                        out_data  <= hold_q[0];
                        out_sof   <= first_q;
                        first_q   <= 1'b0;
                    end else begin
                        fill_q <= fill_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sdlc_rx_chk.sv
module sdlc_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rx_bit,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic out_crc_err
);
    logic [2:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (bit_en) run_q <= rx_bit ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;
    end

    // R4: output pulses only follow a bit strobe
    a_r4_out_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !out_valid);

    // R5: frame markers ride on a delivered byte
    a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r5_eof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R6: check result is reported only at frame end
    a_r6_err_with_eof: assert property (@(posedge clk) disable iff (!rst_n)
        out_crc_err |-> out_eof);

    // R11: a one arriving after five or more ones never yields output
    a_r11_long_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_bit && run_q >= 3'd5) |=> !out_valid);
endmodule

bind sdlc_rx sdlc_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_crc_err(out_crc_err)
);

// File: tb/sdlc_rx_tb.sv
module sdlc_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       addr_search = 1'b0;
    logic [7:0] station_addr = 8'h00;
    logic       out_valid, out_sof, out_eof, out_crc_err;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    sdlc_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .addr_search(addr_search), .station_addr(station_addr),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_crc_err(out_crc_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int tx_ones = 0;

    logic [7:0] got_d [32];
    logic       got_s [32];
    logic       got_e [32];
    logic       got_x [32];
    int         n_got = 0;

    logic [7:0] fb [16];
    int         flen = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && n_got < 32) begin
            got_d[n_got] <= out_data;
            got_s[n_got] <= out_sof;
            got_e[n_got] <= out_eof;
            got_x[n_got] <= out_crc_err;
            n_got <= n_got + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic send_raw(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_dbit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_shared_flag();
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_body(input logic corrupt);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < flen; i++) begin
            send_byte(fb[i]);
            c = crc_step(c, fb[i]);
        end
        c = ~c;
        if (corrupt) c[3] = ~c[3];
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_frame(input string req, input logic err);
        chk({req, " count"}, n_got, flen);
        for (int i = 0; i < flen && i < n_got; i++) begin
            chk({req, " data"}, got_d[i], fb[i]);
            chk({req, " sof"}, got_s[i], (i == 0));
            chk({req, " eof"}, got_e[i], (i == flen - 1));
            chk({req, " crc_err"}, got_x[i], (i == flen - 1) ? err : 1'b0);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        n_got = 0;
    endtask

    // R1 R2: reset values, then bits before any boundary are ignored
    task automatic t_reset_hunt();
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_sof", out_sof, 0);
        chk("R1 out_eof", out_eof, 0);
        chk("R1 out_crc_err", out_crc_err, 0);
        clear_log();
        for (int i = 0; i < 40; i++) send_raw(i[0] ^ i[2]);
        settle();
        chk("R2 no output while hunting", n_got, 0);
    endtask

    // R4 R5 R6 R9: plain frame, search disabled
    task automatic t_basic();
        addr_search = 1'b0;
        clear_log();
        fb[0] = 8'h42; fb[1] = 8'h03; fb[2] = 8'h11; fb[3] = 8'hA5; flen = 4;
        send_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R9_R4_R5", 1'b0);
    endtask

    // R3: payload containing boundary-like and all-ones bytes
    task automatic t_stuffing();
        clear_log();
        fb[0] = 8'h7E; fb[1] = 8'hFF; fb[2] = 8'h3F; fb[3] = 8'h7E; fb[4] = 8'hF8; flen = 5;
        send_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R3", 1'b0);
    endtask

    // R6: corrupted check sequence
    task automatic t_bad_fcs();
        clear_log();
        fb[0] = 8'h10; fb[1] = 8'h20; fb[2] = 8'h30; flen = 3;
        send_flag(); send_body(1'b1); send_flag(); settle();
        expect_frame("R6", 1'b1);
    endtask

    // R7: shared-zero boundary between two frames, preset per frame
    task automatic t_shared();
        clear_log();
        fb[0] = 8'h01; fb[1] = 8'h02; fb[2] = 8'h03; flen = 3;
        send_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R7 first", 1'b0);
        clear_log();
        fb[0] = 8'hC3; fb[1] = 8'h5A; fb[2] = 8'h00; fb[3] = 8'h99; flen = 4;
        send_shared_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R7 second", 1'b0);
    endtask

    // R8: address search rejects and accepts
    task automatic t_addr();
        addr_search  = 1'b1;
        station_addr = 8'h5A;
        clear_log();
        fb[0] = 8'h33; fb[1] = 8'h44; fb[2] = 8'h55; fb[3] = 8'h66; flen = 4;
        send_flag(); send_body(1'b0); send_flag(); settle();
        chk("R8 rejected frame silent", n_got, 0);
        clear_log();
        fb[0] = 8'h5A; fb[1] = 8'h44; fb[2] = 8'h55; flen = 3;
        send_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R8 accepted", 1'b0);
        addr_search = 1'b0;
    endtask

    // R10: two bytes between boundaries
    task automatic t_short();
        clear_log();
        send_flag(); send_byte(8'h42); send_byte(8'h99); send_flag(); settle();
        chk("R10 short frame silent", n_got, 0);
    endtask

    // R11: seven ones abort a frame still held back
    task automatic t_abort();
        clear_log();
        send_flag(); send_byte(8'h42); send_byte(8'h10); send_byte(8'h20);
        for (int i = 0; i < 8; i++) send_raw(1'b1);
        settle();
        chk("R11 aborted frame silent", n_got, 0);
        fb[0] = 8'h42; fb[1] = 8'h77; fb[2] = 8'h88; flen = 3;
        send_flag(); send_body(1'b0); send_flag(); settle();
        expect_frame("R11 recovery", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_hunt();
        t_basic();
        t_stuffing();
        t_bad_fcs();
        t_shared();
        t_addr();
        t_short();
        t_abort();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule